// File: doc/BRIEF.md
# Byte-Stream Command Status Engine

This block is the device-side state keeper for a byte-serial command channel in front of a secure execution engine. A host pushes command bytes one at a time into a data register, watches a status byte to learn when the device has the whole command, sets a start bit, waits for a response-ready flag and then pulls the response bytes out of the same data register. Between the host and the engine the block tracks the interface phase (idle, ready, receiving, executing, completing). It holds the command and the response in two simple dual-port buffers and presents a status byte, an extended status byte and a 16-bit transfer allowance.

The execution engine is outside the block. It sees a one-cycle start pulse, reads the captured command through its own read port, writes response bytes into the response buffer and then raises a done strobe. The engine must not raise done in the same cycle as its last response write. The host may abort a running command. The block then answers with a fixed ten-byte cancelled response and does not wait for the engine. The host may also ask for the buffered response to be sent again from its first byte.

Top module: `fce_cmd_engine`

## Requirements
- R1: After reset the phase is idle. The status byte reads 0x84: bit 7 valid = 1, bit 2 self-test-done = 1, every other bit 0. The transfer allowance reads 0.
- R2: A status write with bit 6 (command-ready) set while idle or completing enters the ready phase. It empties both buffers. The status byte then reads 0xCC (valid, command-ready, expect-more, self-test-done).
- R3: Expect-more (status bit 3) stays 1 until at least 6 bytes have been received and the count reaches the 32-bit big-endian size carried in command bytes 2 to 5. The status byte then reads 0xC4. Data writes made while expect-more is 0, or once the buffer holds CMD_DEPTH bytes, are dropped and do not change the received count.
- R4: The transfer allowance (select 1 low byte, select 2 high byte) is CMD_DEPTH minus the received count while expect-more is 1. While completing it is the number of response bytes not yet read. Otherwise it is 0.
- R5: A status write with bit 5 (go) while receiving with expect-more at 0 raises exec_start for exactly one cycle and enters executing. In that phase the status byte reads 0x04, because the valid bit drops. A go bit written at any other time is ignored.
- R6: On exec_done the block enters completing. The status byte reads 0x94 (data-available set) while unread response bytes remain. Data reads return the response bytes in order, and the status byte reads 0x84 after the last byte.
- R7: Writing 1 to bit 0 of the extended status byte (select 3) while executing raises exec_abort for one cycle and enters completing. The response is then the 10 bytes 80 01 00 00 00 0A 00 00 09 09.
- R8: A cancel written while completing is ignored: there is no abort pulse and the response read position does not change.
- R9: A status write with bit 1 (retry) while completing restarts the response from its first byte.
- R10: The extended status byte reads 0x04: bits 3:2 hold family code 01 and the cancel bit reads 0.
- R11: A data read (select 4) when no response byte is available returns 0xFF and changes nothing.
- R12: The engine reads command byte cmd_rd_addr on cmd_rd_data one clock later, and cmd_len gives the received count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Host write select: 0 status, 3 extended status, 4 data |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 3 | Host read select: 0 status, 1/2 allowance low/high, 3 extended status, 4 data |
| rd_data | output | 8 | Read byte, registered, valid the clock after rd_en |
| exec_start | output | 1 | One-cycle pulse: command handed to the engine |
| exec_abort | output | 1 | One-cycle pulse: engine must stop |
| exec_done | input | 1 | Engine finished writing the response |
| exec_resp_we | input | 1 | Engine response byte write strobe |
| exec_resp_data | input | 8 | Engine response byte |
| cmd_rd_addr | input | $clog2(CMD_DEPTH) | Engine command read address |
| cmd_rd_data | output | 8 | Command byte, one clock after the address |
| cmd_len | output | $clog2(CMD_DEPTH+1) | Number of command bytes received |

## Verification
The bench builds the block with CMD_DEPTH and RESP_DEPTH both set to 16 instead of 64. A command whose size field asks for 20 bytes therefore runs into the buffer limit after a handful of writes. That makes the dropped-write rule and a zero transfer allowance with expect-more still set observable. The small depth also keeps the ten-byte cancelled response, the retry replay and the in-order response read inside one short run.

// File: rtl/fce_pkg.sv
package fce_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } fce_state_e;

  // host register selects
  localparam logic [2:0] SEL_STS      = 3'd0;
  localparam logic [2:0] SEL_BURST_LO = 3'd1;
  localparam logic [2:0] SEL_BURST_HI = 3'd2;
  localparam logic [2:0] SEL_STSX     = 3'd3;
  localparam logic [2:0] SEL_DATA     = 3'd4;

  // status byte bit positions
  localparam int B_VALID = 7;
  localparam int B_READY = 6;
  localparam int B_GO    = 5;
  localparam int B_AVAIL = 4;
  localparam int B_MORE  = 3;
  localparam int B_SELFT = 2;
  localparam int B_RETRY = 1;

  // extended status
  localparam int         BX_CANCEL = 0;
  localparam logic [1:0] FAMILY    = 2'b01;

  // command header: size field sits in bytes 2..5
  localparam int HDR_BYTES  = 6;
  localparam int SIZE_FIRST = 2;
  localparam int SIZE_LAST  = 5;

  localparam int CANCEL_LEN = 10;

  function automatic logic [7:0] cancel_byte(input logic [3:0] idx, input logic [31:0] code);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h80;
      4'd1:    b = 8'h01;
      4'd5:    b = 8'(CANCEL_LEN);
      4'd6:    b = code[31:24];
      4'd7:    b = code[23:16];
      4'd8:    b = code[15:8];
      4'd9:    b = code[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/fce_sdp_ram.sv
module fce_sdp_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fce_len_tracker.sv
module fce_len_tracker #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          byte_we,
  input  logic [CW-1:0] byte_idx,
  input  logic [7:0]    byte_val,
  input  logic [CW-1:0] count,
  output logic          expect_more
);
  import fce_pkg::*;

  localparam logic [CW-1:0] HDR_N = CW'(HDR_BYTES);
  localparam logic [CW-1:0] SZ_LO = CW'(SIZE_FIRST);
  localparam logic [CW-1:0] SZ_HI = CW'(SIZE_LAST);

  logic [31:0] size_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      size_q <= '0;
    end else if (byte_we && byte_idx >= SZ_LO && byte_idx <= SZ_HI) begin
      size_q <= {size_q[23:0], byte_val};
    end
  end

  always_comb begin
    expect_more = (count < HDR_N) || ({{(32-CW){1'b0}}, count} < size_q);
  end

endmodule

// File: rtl/fce_status_fmt.sv
module fce_status_fmt #(
  parameter int CMD_DEPTH = 64,
  parameter int CW        = 7,
  parameter int RW        = 7
) (
  input  fce_pkg::fce_state_e state,
  input  logic                expect_more,
  input  logic                data_avail,
  input  logic [CW-1:0]       wcnt,
  input  logic [RW-1:0]       rptr,
  input  logic [RW-1:0]       rlen,
  output logic [7:0]          sts,
  output logic [15:0]         burst
);
  import fce_pkg::*;

  localparam logic [CW-1:0] CMD_MAX = CW'(CMD_DEPTH);

  logic in_rx;
  logic [CW-1:0] room;
  logic [RW-1:0] left;

  always_comb begin
    in_rx = (state == ST_READY) || (state == ST_RECV);
    room  = CMD_MAX - wcnt;
    left  = rlen - rptr;

    sts          = '0;
    sts[B_VALID] = (state != ST_EXEC);
    sts[B_READY] = in_rx;
    sts[B_GO]    = 1'b0;
    sts[B_AVAIL] = data_avail;
    sts[B_MORE]  = in_rx && expect_more;
    sts[B_SELFT] = 1'b1;
    sts[B_RETRY] = 1'b0;

    if (in_rx && expect_more)  burst = 16'(room);
    else if (state == ST_DONE) burst = 16'(left);
    else                       burst = '0;
  end

endmodule

// File: rtl/fce_cmd_engine.sv
module fce_cmd_engine #(
  parameter int          CMD_DEPTH   = 64,
  parameter int          RESP_DEPTH  = 64,
  parameter logic [31:0] CANCEL_CODE = 32'h0000_0909,
  localparam int         CAW         = $clog2(CMD_DEPTH),
  localparam int         CW          = $clog2(CMD_DEPTH + 1),
  localparam int         RAW         = $clog2(RESP_DEPTH),
  localparam int         RW          = $clog2(RESP_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [2:0]     wr_sel,
  input  logic [7:0]     wr_data,
  input  logic           rd_en,
  input  logic [2:0]     rd_sel,
  output logic [7:0]     rd_data,
  output logic           exec_start,
  output logic           exec_abort,
  input  logic           exec_done,
  input  logic           exec_resp_we,
  input  logic [7:0]     exec_resp_data,
  input  logic [CAW-1:0] cmd_rd_addr,
  output logic [7:0]     cmd_rd_data,
  output logic [CW-1:0]  cmd_len
);
  import fce_pkg::*;

  localparam logic [CW-1:0] CMD_MAX  = CW'(CMD_DEPTH);
  localparam logic [RW-1:0] RESP_MAX = RW'(RESP_DEPTH);
  localparam logic [RW-1:0] CANC_N   = RW'(CANCEL_LEN);

  fce_state_e    state;
  logic [CW-1:0] wcnt;
  logic [RW-1:0] rptr, rptr_nxt, rlen, rwptr;
  logic          cancelled;
  logic          start_q, abort_q;
  logic [7:0]    rd_q;

  logic          in_rx, expect_more, data_avail;
  logic          sts_wr, stsx_wr, data_wr, resp_we, rd_fire;
  logic          do_ready, do_go, do_retry, do_cancel;
  logic [7:0]    sts_byte, resp_q;
  logic [15:0]   burst;

  // request decode
  always_comb begin
    in_rx      = (state == ST_READY) || (state == ST_RECV);
    sts_wr     = wr_en && (wr_sel == SEL_STS);
    stsx_wr    = wr_en && (wr_sel == SEL_STSX);
    data_wr    = wr_en && (wr_sel == SEL_DATA) && in_rx && expect_more && (wcnt < CMD_MAX);
    do_ready   = sts_wr && wr_data[B_READY] && ((state == ST_IDLE) || (state == ST_DONE));
    do_go      = sts_wr && wr_data[B_GO] && (state == ST_RECV) && !expect_more;
    do_retry   = sts_wr && wr_data[B_RETRY] && (state == ST_DONE) && !do_ready;
    do_cancel  = stsx_wr && wr_data[BX_CANCEL] && (state == ST_EXEC);
    data_avail = (state == ST_DONE) && (rptr < rlen);
    rd_fire    = rd_en && (rd_sel == SEL_DATA) && data_avail;
    resp_we    = (state == ST_EXEC) && exec_resp_we && (rwptr < RESP_MAX);

    if (do_ready || do_retry) rptr_nxt = '0;
    else if (rd_fire)         rptr_nxt = rptr + 1'b1;
    else                      rptr_nxt = rptr;
  end

  // phase machine and pointers
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wcnt      <= '0;
      rptr      <= '0;
      rlen      <= '0;
      rwptr     <= '0;
      cancelled <= 1'b0;
      start_q   <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      start_q <= do_go;
      abort_q <= do_cancel;
      rptr    <= rptr_nxt;
      if (resp_we) rwptr <= rwptr + 1'b1;

      case (state)
        ST_IDLE, ST_DONE: begin
          if (do_ready) begin
            state     <= ST_READY;
            wcnt      <= '0;
            rlen      <= '0;
            rwptr     <= '0;
            cancelled <= 1'b0;
          end
        end
        ST_READY, ST_RECV: begin
          if (data_wr) begin
            wcnt  <= wcnt + 1'b1;
            state <= ST_RECV;
          end
          if (do_go) begin
            state     <= ST_EXEC;
            rwptr     <= '0;
            rlen      <= '0;
            cancelled <= 1'b0;
          end
        end
        ST_EXEC: begin
          if (do_cancel) begin
            state     <= ST_DONE;
            cancelled <= 1'b1;
            rlen      <= CANC_N;
          end else if (exec_done) begin
            state <= ST_DONE;
            rlen  <= rwptr;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // registered host read
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      case (rd_sel)
        SEL_STS:      rd_q <= sts_byte;
        SEL_BURST_LO: rd_q <= burst[7:0];
        SEL_BURST_HI: rd_q <= burst[15:8];
        SEL_STSX:     rd_q <= {4'b0000, FAMILY, 2'b00};
        SEL_DATA: begin
          if (!data_avail)    rd_q <= 8'hFF;
          else if (cancelled) rd_q <= cancel_byte(rptr[3:0], CANCEL_CODE);
          else                rd_q <= resp_q;
        end
        default:      rd_q <= 8'hFF;
      endcase
    end
  end

  fce_len_tracker #(.CW(CW)) i_len (
    .clk         (clk),
    .rst         (rst),
    .clear       (do_ready),
    .byte_we     (data_wr),
    .byte_idx    (wcnt),
    .byte_val    (wr_data),
    .count       (wcnt),
    .expect_more (expect_more)
  );

  fce_status_fmt #(.CMD_DEPTH(CMD_DEPTH), .CW(CW), .RW(RW)) i_fmt (
    .state       (state),
    .expect_more (expect_more),
    .data_avail  (data_avail),
    .wcnt        (wcnt),
    .rptr        (rptr),
    .rlen        (rlen),
    .sts         (sts_byte),
    .burst       (burst)
  );

  fce_sdp_ram #(.DW(8), .DEPTH(CMD_DEPTH), .AW(CAW)) i_cmd_ram (
    .clk   (clk),
    .we    (data_wr),
    .waddr (wcnt[CAW-1:0]),
    .wdata (wr_data),
    .raddr (cmd_rd_addr),
    .rdata (cmd_rd_data)
  );

  // read address looks ahead so the next byte is ready on the next edge
  fce_sdp_ram #(.DW(8), .DEPTH(RESP_DEPTH), .AW(RAW)) i_resp_ram (
    .clk   (clk),
    .we    (resp_we),
    .waddr (rwptr[RAW-1:0]),
    .wdata (exec_resp_data),
    .raddr (rptr_nxt[RAW-1:0]),
    .rdata (resp_q)
  );

  assign rd_data    = rd_q;
  assign exec_start = start_q;
  assign exec_abort = abort_q;
  assign cmd_len    = wcnt;

endmodule

// File: rtl/fce_checker.sv
module fce_checker #(
  parameter int CMD_DEPTH = 64,
  parameter int CW        = 7,
  parameter int RW        = 7
) (
  input logic                clk,
  input logic                rst,
  input fce_pkg::fce_state_e state,
  input logic                exec_start,
  input logic                exec_abort,
  input logic [CW-1:0]       wcnt,
  input logic [RW-1:0]       rptr,
  input logic [RW-1:0]       rlen
);
  import fce_pkg::*;

  localparam logic [CW-1:0] CMD_MAX = CW'(CMD_DEPTH);

  a_r5_start_single: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> !exec_start);

  a_r5_start_in_exec: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> state == ST_EXEC);

  a_r7_abort_from_exec: assert property (@(posedge clk) disable iff (rst)
    exec_abort |-> (state == ST_DONE) && ($past(state) == ST_EXEC));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wcnt <= CMD_MAX);

  a_r6_read_bound: assert property (@(posedge clk) disable iff (rst)
    rptr <= rlen);

  a_r2_ready_empty: assert property (@(posedge clk) disable iff (rst)
    state == ST_READY |-> wcnt == '0);

  a_r12_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
    state == ST_EXEC |=> $stable(wcnt));

endmodule

bind fce_cmd_engine fce_checker #(.CMD_DEPTH(CMD_DEPTH), .CW(CW), .RW(RW)) i_fce_checker (
  .clk        (clk),
  .rst        (rst),
  .state      (state),
  .exec_start (exec_start),
  .exec_abort (exec_abort),
  .wcnt       (wcnt),
  .rptr       (rptr),
  .rlen       (rlen)
);

// File: tb/test_fce_cmd_engine.sv
module test_fce_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int CAW        = $clog2(DEPTH);
  localparam int CW         = $clog2(DEPTH + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [2:0]     wr_sel = '0;
  logic [7:0]     wr_data = '0;
  logic           rd_en = 1'b0;
  logic [2:0]     rd_sel = '0;
  logic [7:0]     rd_data;
  logic           exec_start, exec_abort;
  logic           exec_done = 1'b0;
  logic           exec_resp_we = 1'b0;
  logic [7:0]     exec_resp_data = '0;
  logic [CAW-1:0] cmd_rd_addr = '0;
  logic [7:0]     cmd_rd_data;
  logic [CW-1:0]  cmd_len;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;
  logic seen_start, seen_abort;

  always #(CLK_PERIOD/2) clk = ~clk;

  fce_cmd_engine #(.CMD_DEPTH(DEPTH), .RESP_DEPTH(DEPTH)) i_fce_cmd_engine (
    .clk, .rst, .wr_en, .wr_sel, .wr_data, .rd_en, .rd_sel, .rd_data,
    .exec_start, .exec_abort, .exec_done, .exec_resp_we, .exec_resp_data,
    .cmd_rd_addr, .cmd_rd_data, .cmd_len
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic host_wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    seen_start = exec_start;
    seen_abort = exec_abort;
  endtask

  task automatic host_rd(input logic [2:0] sel, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic expect_rd(input string req, input logic [2:0] sel, input logic [7:0] exp);
    logic [7:0] d;
    host_rd(sel, d);
    check(req, int'(d), int'(exp));
  endtask

  task automatic engine_respond(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      exec_resp_we = 1'b1; exec_resp_data = base + 8'(i);
    end
    @(negedge clk);
    exec_resp_we = 1'b0; exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
  endtask

  task automatic t_reset;
    expect_rd("R1 status", 3'd0, 8'h84);
    expect_rd("R1 allowance", 3'd1, 8'h00);
    expect_rd("R10 ext status", 3'd3, 8'h04);
    expect_rd("R11 empty data read", 3'd4, 8'hFF);
  endtask

  task automatic t_normal;
    logic [7:0] cmd [10] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h01, 8'h44};
    host_wr(3'd0, 8'h40);
    expect_rd("R2 ready status", 3'd0, 8'hCC);
    expect_rd("R4 allowance empty", 3'd1, 8'(DEPTH));
    for (int i = 0; i < 3; i++) host_wr(3'd4, cmd[i]);
    expect_rd("R3 still expecting", 3'd0, 8'hCC);
    expect_rd("R4 allowance after 3", 3'd1, 8'(DEPTH - 3));
    for (int i = 3; i < 10; i++) host_wr(3'd4, cmd[i]);
    expect_rd("R3 complete status", 3'd0, 8'hC4);
    expect_rd("R4 allowance complete", 3'd1, 8'h00);
    host_wr(3'd4, 8'hEE);
    check("R3 extra byte dropped", int'(cmd_len), 10);
    @(negedge clk); cmd_rd_addr = CAW'(9);
    @(negedge clk);
    check("R12 engine command read", int'(cmd_rd_data), 8'h44);
    host_wr(3'd0, 8'h20);
    check("R5 start pulse", int'(seen_start), 1);
    @(negedge clk);
    check("R5 start one cycle", int'(exec_start), 0);
    expect_rd("R5 executing status", 3'd0, 8'h04);
    engine_respond(4, 8'hA0);
    expect_rd("R6 data available", 3'd0, 8'h94);
    expect_rd("R4 allowance response", 3'd1, 8'h04);
    host_wr(3'd3, 8'h01);
    check("R8 no abort after data", int'(seen_abort), 0);
    expect_rd("R8 first byte intact", 3'd4, 8'hA0);
    expect_rd("R6 second byte", 3'd4, 8'hA1);
    expect_rd("R4 allowance remaining", 3'd1, 8'h02);
    host_wr(3'd0, 8'h02);
    expect_rd("R9 retry replays first", 3'd4, 8'hA0);
    expect_rd("R6 byte 1", 3'd4, 8'hA1);
    expect_rd("R6 byte 2", 3'd4, 8'hA2);
    expect_rd("R6 byte 3", 3'd4, 8'hA3);
    expect_rd("R6 drained status", 3'd0, 8'h84);
    expect_rd("R11 drained data read", 3'd4, 8'hFF);
  endtask

  task automatic t_cancel;
    logic [7:0] exp [10] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h09, 8'h09};
    host_wr(3'd0, 8'h40);
    expect_rd("R2 ready from completing", 3'd0, 8'hCC);
    for (int i = 0; i < 6; i++) host_wr(3'd4, (i == 5) ? 8'h06 : 8'h00);
    expect_rd("R3 header-only command", 3'd0, 8'hC4);
    host_wr(3'd0, 8'h20);
    check("R5 start for cancel run", int'(seen_start), 1);
    host_wr(3'd3, 8'h01);
    check("R7 abort pulse", int'(seen_abort), 1);
    expect_rd("R7 cancelled data avail", 3'd0, 8'h94);
    for (int i = 0; i < 10; i++) expect_rd("R7 cancelled byte", 3'd4, exp[i]);
  endtask

  task automatic t_overflow;
    host_wr(3'd0, 8'h40);
    host_wr(3'd4, 8'h80); host_wr(3'd4, 8'h01); host_wr(3'd4, 8'h00);
    host_wr(3'd0, 8'h20);
    check("R5 early go ignored", int'(seen_start), 0);
    expect_rd("R5 status after early go", 3'd0, 8'hCC);
    host_wr(3'd4, 8'h00); host_wr(3'd4, 8'h00); host_wr(3'd4, 8'h14);
    for (int i = 0; i < 10; i++) host_wr(3'd4, 8'h55);
    check("R3 buffer full count", int'(cmd_len), DEPTH);
    expect_rd("R4 allowance at full", 3'd1, 8'h00);
    expect_rd("R3 expect kept at full", 3'd0, 8'hCC);
    host_wr(3'd4, 8'h66);
    check("R3 write past depth dropped", int'(cmd_len), DEPTH);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_normal;
    t_cancel;
    t_overflow;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule